// File: doc/BRIEF.md
# Reloading Down-Counter Timer

This block is a down-counting timer behind a small 32-bit register bus. Software writes a start value, picks a pacing source and a counting mode, and enables it. On every cycle in which the chosen tick-enable input is high, the counter steps down by one. When a tick lands while the counter is at zero, the counter underflows and a level interrupt is raised.

In periodic mode an underflow reloads the counter from the stored start value, which gives a steady stream of events. In free-running mode the counter wraps to all ones. The interrupt stays high until software writes the acknowledge register. The counter width is a parameter and may be 16 or 32 bits. The tick enables come from prescalers outside the block.

Counting is controlled by a two-state machine. In `ST_OFF` the counter holds its value. In `ST_RUN` it counts. A control write with the enable bit set takes the START transition from `ST_OFF` to `ST_RUN`. A control write with the enable bit clear takes the STOP transition from `ST_RUN` to `ST_OFF`. Every other cycle keeps the current state.

Top module: `dtimer`

## Requirements
- R1: After reset, the start value, the counter, the control bits and the interrupt are all zero.
- R2: Word offsets decoded from address bits [3:2]. 0x0 is the start value, 0x4 is the counter (read-only), 0x8 is control and 0xC is the acknowledge register, which reads zero. In control, bit 7 is enable, bit 6 is periodic and bit 3 is fast-tick select. All other control bits read zero. Values are zero-extended to 32 bits.
- R3: A write to 0x0 stores the low CNT_W bits as the start value and also loads the counter at the same clock edge.
- R4: A write to 0x4 has no effect.
- R5: While enabled, the counter decrements by one on each cycle in which the selected tick is high. Bit 3 = 1 selects `fast_tick`; bit 3 = 0 selects `slow_tick`. The unselected tick has no effect.
- R6: While disabled (bit 7 = 0), the counter holds and no new interrupt is raised. Writing 0 to control disables the timer.
- R7: In periodic mode (bit 6 = 1), a tick at zero reloads the start value and sets `irq` at that edge.
- R8: In free-running mode (bit 6 = 0), a tick at zero wraps the counter to all ones and sets `irq`.
- R9: `irq` stays high until a write of any data to 0xC, which clears it at that edge.
- R10: When an underflow and an acknowledge write fall in the same cycle, `irq` stays high.
- R11: When a write to 0x0 and a tick fall in the same cycle, the written value wins and no underflow is taken.
- R12: The counter width CNT_W (16 or 32) bounds the counter, the start value and the wrap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| fast_tick | input | 1 | Fast pacing enable, one cycle per tick |
| slow_tick | input | 1 | Slow pacing enable, one cycle per tick |
| irq | output | 1 | Level interrupt on underflow |

## Verification
If the run/off state were wrong, the counter at 0x4 would move when it should hold, or hold when it should move. That would show at the first tick after the control write. A wrong counter value shows up one cycle after the edge that produced it, through 0x4 or through the time of the next `irq`. A wrong interrupt latch shows on `irq` at the edge of an underflow or an acknowledge. A bench model updated on every edge catches all of these within one cycle. Two widths run side by side, so a wrap or truncation error in one is exposed at once.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
    localparam int DATA_W = 32;

    // word offsets (address bits [3:2])
    localparam logic [1:0] OFS_LOAD  = 2'd0;
    localparam logic [1:0] OFS_VALUE = 2'd1;
    localparam logic [1:0] OFS_CTRL  = 2'd2;
    localparam logic [1:0] OFS_ACK   = 2'd3;

    // control bit positions
    localparam int BIT_EN   = 7;
    localparam int BIT_PER  = 6;
    localparam int BIT_FAST = 3;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_e;
endpackage

// File: rtl/dtimer_regs.sv
module dtimer_regs
    import dtimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              running,
    output logic              wr_load,
    output logic              wr_ctrl,
    output logic              wr_ack,
    output logic [CNT_W-1:0]  load_q,
    output logic              periodic,
    output logic              fast_sel,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [1:0] word;
    logic       unused_bits;

    assign word        = bus_addr[3:2];
    assign unused_bits = ^{bus_addr, bus_wdata};

    assign wr_load = bus_wen && (word == OFS_LOAD);
    assign wr_ctrl = bus_wen && (word == OFS_CTRL);
    assign wr_ack  = bus_wen && (word == OFS_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q   <= '0;
            periodic <= 1'b0;
            fast_sel <= 1'b0;
        end else begin
            if (wr_load) begin
                load_q <= bus_wdata[CNT_W-1:0];
            end
            if (wr_ctrl) begin
                periodic <= bus_wdata[BIT_PER];
                fast_sel <= bus_wdata[BIT_FAST];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (word)
            OFS_LOAD:  bus_rdata[CNT_W-1:0] = load_q;
            OFS_VALUE: bus_rdata[CNT_W-1:0] = cnt;
            OFS_CTRL: begin
                bus_rdata[BIT_EN]   = running;
                bus_rdata[BIT_PER]  = periodic;
                bus_rdata[BIT_FAST] = fast_sel;
            end
            OFS_ACK:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dtimer_core.sv
module dtimer_core
    import dtimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             wr_ctrl,
    input  logic             ctrl_en,
    input  logic             wr_ack,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_ONES = '1;

    run_state_e state_q, state_d;
    logic       underflow;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions: START (OFF->RUN), STOP (RUN->OFF)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (wr_ctrl && ctrl_en)  state_d = ST_RUN;
            ST_RUN: if (wr_ctrl && !ctrl_en) state_d = ST_OFF;
        endcase
    end

    assign running   = (state_q == ST_RUN);
    assign underflow = running && tick && (cnt == '0) && !wr_load;

    // outputs: counter and interrupt latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            if (wr_load) begin
                cnt <= load_val;
            end else if (running && tick) begin
                if (cnt == '0) cnt <= periodic ? load_q : CNT_ONES;
                else           cnt <= cnt - 1'b1;
            end
            irq <= underflow || (irq && !wr_ack);
        end
    end
endmodule

// File: rtl/dtimer.sv
module dtimer
    import dtimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fast_tick,
    input  logic              slow_tick,
    output logic              irq
);
    logic             wr_load, wr_ctrl, wr_ack;
    logic             periodic, fast_sel, running, tick_sel;
    logic [CNT_W-1:0] load_q, cnt;

    assign tick_sel = fast_sel ? fast_tick : slow_tick;

    dtimer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wen   (bus_wen),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .running   (running),
        .wr_load   (wr_load),
        .wr_ctrl   (wr_ctrl),
        .wr_ack    (wr_ack),
        .load_q    (load_q),
        .periodic  (periodic),
        .fast_sel  (fast_sel),
        .bus_rdata (bus_rdata)
    );

    dtimer_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_load  (wr_load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .wr_ctrl  (wr_ctrl),
        .ctrl_en  (bus_wdata[BIT_EN]),
        .wr_ack   (wr_ack),
        .tick     (tick_sel),
        .periodic (periodic),
        .load_q   (load_q),
        .cnt      (cnt),
        .running  (running),
        .irq      (irq)
    );
endmodule

// File: rtl/dtimer_chk.sv
module dtimer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_load,
    input logic             wr_ack,
    input logic             running,
    input logic             periodic,
    input logic             tick_sel,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load_q,
    input logic             irq
);
    a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !wr_ack |=> irq);

    a_r6_off_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !irq |=> !irq);

    a_r6_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !wr_load |=> $stable(cnt));

    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        running && tick_sel && cnt != '0 && !wr_load |=> cnt == $past(cnt) - 1'b1);

    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        running && periodic && tick_sel && cnt == '0 && !wr_load
        |=> cnt == $past(load_q) && irq);

    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        running && !periodic && tick_sel && cnt == '0 && !wr_load
        |=> (&cnt) && irq);

    a_r10_ack_race: assert property (@(posedge clk) disable iff (!rst_n)
        running && tick_sel && cnt == '0 && !wr_load && wr_ack |=> irq);

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> cnt == load_q);
endmodule

bind dtimer dtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_load  (wr_load),
    .wr_ack   (wr_ack),
    .running  (running),
    .periodic (periodic),
    .tick_sel (tick_sel),
    .cnt      (cnt),
    .load_q   (load_q),
    .irq      (irq)
);

// File: tb/test_dtimer.sv
`timescale 1ns/1ps
module test_dtimer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wen = 1'b0;
    logic [31:0] wdata = '0;
    logic        ft = 1'b0, st = 1'b0;
    logic [31:0] rd32, rd16;
    logic        irq32, irq16;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dtimer #(.CNT_W(32), .ADDR_W(4)) i_dtimer (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen),
        .bus_wdata(wdata), .bus_rdata(rd32), .fast_tick(ft),
        .slow_tick(st), .irq(irq32));

    dtimer #(.CNT_W(16), .ADDR_W(4)) i_dtimer_w16 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen),
        .bus_wdata(wdata), .bus_rdata(rd16), .fast_tick(ft),
        .slow_tick(st), .irq(irq16));

    // behavioural reference, index 0 = 32-bit, 1 = 16-bit
    longint m_load[2], m_cnt[2];
    bit     m_irq[2];
    bit     m_en, m_per, m_fast;
    longint msk[2] = '{64'hFFFF_FFFF, 64'hFFFF};

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_load[k] = 0; m_cnt[k] = 0; m_irq[k] = 0;
            end
            m_en = 0; m_per = 0; m_fast = 0;
        end else begin
            bit tk, wl, wc, wa;
            tk = m_fast ? ft : st;
            wl = wen && addr[3:2] == 2'd0;
            wc = wen && addr[3:2] == 2'd2;
            wa = wen && addr[3:2] == 2'd3;
            for (int k = 0; k < 2; k++) begin
                bit uf;
                uf = m_en && tk && m_cnt[k] == 0 && !wl;
                m_irq[k] = uf || (m_irq[k] && !wa);
                if (wl) begin
                    m_cnt[k]  = longint'(wdata) & msk[k];
                    m_load[k] = longint'(wdata) & msk[k];
                end else if (m_en && tk) begin
                    if (m_cnt[k] == 0) m_cnt[k] = m_per ? m_load[k] : msk[k];
                    else               m_cnt[k] = m_cnt[k] - 1;
                end
            end
            if (wc) begin
                m_en = wdata[7]; m_per = wdata[6]; m_fast = wdata[3];
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic longint model_rd(input int k);
        case (addr[3:2])
            2'd0: return m_load[k];
            2'd1: return m_cnt[k];
            2'd2: return {m_en, m_per, 2'b00, m_fast, 3'b000};
            default: return 0;
        endcase
    endfunction

    task automatic cmp_all();
        chk("R2", "read32 vs model", longint'(rd32), model_rd(0));
        chk("R2", "read16 vs model", longint'(rd16), model_rd(1));
        chk("R9", "irq32 vs model", longint'(irq32), longint'(m_irq[0]));
        chk("R9", "irq16 vs model", longint'(irq16), longint'(m_irq[1]));
    endtask

    task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d,
                        input logic f, input logic s);
        addr = a; wen = w; wdata = d; ft = f; st = s;
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step(4'h0, 0, 0, 0, 0); chk("R1", "load", rd32, 0);
        step(4'h4, 0, 0, 0, 0); chk("R1", "value", rd32, 0);
        step(4'h8, 0, 0, 0, 0); chk("R1", "control", rd32, 0);
        chk("R1", "irq", irq32, 0);

        // R12: truncation to CNT_W
        step(4'h0, 1, 32'h12345, 0, 0);
        step(4'h0, 0, 0, 0, 0); chk("R12", "load w16", rd16, 32'h2345);
        chk("R12", "load w32", rd32, 32'h12345);

        // R3: load write sets counter
        step(4'h0, 1, 5, 0, 0);
        step(4'h4, 0, 0, 0, 0); chk("R3", "value after load", rd32, 5);

        // R4: value register is read-only
        step(4'h4, 1, 32'h99, 0, 0); chk("R4", "value after write", rd32, 5);

        // R2: control readback keeps only bits 7,6,3
        step(4'h8, 1, 32'hFF, 0, 0); chk("R2", "control mask", rd32, 32'hC8);

        // R5: fast ticks count down
        for (int i = 0; i < 5; i++) step(4'h4, 0, 0, 1, 0);
        chk("R5", "value at zero", rd32, 0);
        chk("R5", "no irq yet", irq32, 0);

        // R7: periodic reload on underflow
        step(4'h4, 0, 0, 1, 0);
        chk("R7", "reload value", rd32, 5);
        chk("R7", "irq set", irq32, 1);

        // R5: slow tick ignored while fast selected
        for (int i = 0; i < 3; i++) step(4'h4, 0, 0, 0, 1);
        chk("R5", "slow ignored", rd32, 5);
        chk("R9", "irq held", irq32, 1);

        // R9: any write to ack clears
        step(4'hC, 1, 0, 0, 0); chk("R9", "irq cleared", irq32, 0);

        // R10: underflow with simultaneous ack
        for (int i = 0; i < 5; i++) step(4'h4, 0, 0, 1, 0);
        step(4'hC, 1, 32'hAB, 1, 0);
        chk("R10", "irq kept", irq32, 1);
        chk("R2", "ack reads zero", rd32, 0);
        step(4'h4, 0, 0, 0, 0); chk("R10", "reloaded", rd32, 5);

        // R5: slow tick selected
        step(4'h8, 1, 32'hC0, 0, 0);
        step(4'h4, 0, 0, 0, 1); chk("R5", "slow paces", rd32, 4);
        step(4'h4, 0, 0, 1, 0); chk("R5", "fast ignored", rd32, 4);

        // R6: disabled holds, no irq
        step(4'hC, 1, 0, 0, 0);
        step(4'h8, 1, 0, 0, 0);
        step(4'h0, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(4'h4, 0, 0, 1, 1);
        chk("R6", "held at zero", rd32, 0);
        chk("R6", "no irq", irq32, 0);

        // R8: free-running wrap
        step(4'h8, 1, 32'h88, 0, 0);
        step(4'h4, 0, 0, 1, 0);
        chk("R8", "wrap w32", rd32, 32'hFFFF_FFFF);
        chk("R8", "irq", irq32, 1);
        chk("R12", "wrap w16", rd16, 32'hFFFF);
        step(4'h4, 0, 0, 1, 0); chk("R8", "continues", rd32, 32'hFFFF_FFFE);

        // R11: load beats tick and suppresses underflow
        step(4'hC, 1, 0, 0, 0);
        step(4'h0, 1, 7, 1, 1);
        step(4'h4, 0, 0, 0, 0); chk("R11", "load wins", rd32, 7);
        step(4'h0, 1, 0, 0, 0);
        step(4'h0, 1, 3, 1, 0);
        step(4'h4, 0, 0, 0, 0);
        chk("R11", "load at zero", rd32, 3);
        chk("R11", "no underflow", irq32, 0);

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 19);
            case (r)
                0: step(4'h8, 1, $urandom, 0, 0);
                1: step(4'h0, 1, $urandom_range(0, 6), $urandom_range(0, 1), 1);
                2: step(4'hC, 1, $urandom, $urandom_range(0, 1), $urandom_range(0, 1));
                3: step(4'h4, 1, $urandom, 1, 0);
                default: step(4'({$urandom_range(0, 3), 2'b00}), 0, 0,
                              $urandom_range(0, 1), $urandom_range(0, 1));
            endcase
        end

        report();
    end
endmodule